// File: doc/BRIEF.md
# Gated Integer Clock-Channel Divider

This block thins a stream of parent clock-enable pulses. It emits one single-cycle output enable for every N parent pulses. N is the product of an 8-bit programmable divisor and a fixed post-divide factor that is set per instance by a parameter. The divisor and a disable flag live in a small control register. Software writes that register through a write strobe, and reset loads it with a per-instance default word.

A separate hold input can also stop the channel. It comes from a control register shared by all channels of the same source. While the channel is stopped, by the disable flag or by hold, the output stays low and the pulse counter is cleared. Counting starts again from zero when the channel runs again.

A new divisor never cuts a period short. The ratio in use is reloaded only at an output boundary, or while the channel is stopped.

Top module: `chdiv_channel`

## Requirements
- R1: While the disable flag (control word bit 8) is 1, `tick_o` stays 0 and the pulse counter is held at zero.
- R2: While `hold_i` is 1, `tick_o` stays 0 and the pulse counter is held at zero, whatever the disable flag holds.
- R3: A divisor field (control word bits 7:0) of 0 acts as 255.
- R4: With the channel running, `tick_o` is high for one cycle in the cycle after every ratio-th parent pulse. The ratio is the effective divisor times `FIXED_DIV`.
- R5: In a cycle that follows a cycle with no parent pulse, `tick_o` is 0.
- R6: Reset is synchronous and active high. It loads the control register with `RESET_WORD`, clears the counter and drives `tick_o` to 0.
- R7: A divisor written in the middle of a period takes effect only after the next output pulse, or at once if the channel is stopped.
- R8: After disable or hold is released, the first output pulse comes after exactly one full ratio of parent pulses.
- R9: A word written with `cfg_we_i` = 1 is in the control register from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ptick_i | input | 1 | Parent clock-enable pulse |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_word_i | input | 9 | Control word: bit 8 disable, bits 7:0 divisor |
| hold_i | input | 1 | Hold from the shared per-source register |
| tick_o | output | 1 | Divided output enable pulse |

## Verification
The bench drives a divisor change partway through a period. A design that reloads the ratio at once would emit a short period there. It re-enables the channel after a partial count, which catches a counter that resumes its old value instead of starting from zero. It programs a divisor of zero to catch a design that treats that value as divide-by-zero, or as one, instead of 255 times the fixed factor. It also applies hold while the disable flag is clear, and leaves the parent stream idle, to expose any output that leaks past either gate.

// File: rtl/chdiv_pkg.sv
package chdiv_pkg;

    localparam int CHD_DIV_W  = 8;
    localparam int CHD_CTRL_W = CHD_DIV_W + 1;

    typedef struct packed {
        logic                 off;
        logic [CHD_DIV_W-1:0] div;
    } chd_ctrl_t;

    // A zero divisor selects the largest value the field can hold.
    function automatic logic [CHD_DIV_W-1:0] chd_div_sel(input logic [CHD_DIV_W-1:0] d);
        return (d == '0) ? {CHD_DIV_W{1'b1}} : d;
    endfunction

endpackage

// File: rtl/chdiv_ctrl_reg.sv
module chdiv_ctrl_reg
    import chdiv_pkg::*;
#(
    parameter chd_ctrl_t RESET_WORD = '0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  chd_ctrl_t wdata,
    output chd_ctrl_t ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= RESET_WORD;
        end else if (we) begin
            ctrl_q <= wdata;
        end
    end

endmodule

// File: rtl/chdiv_ratio.sv
module chdiv_ratio
    import chdiv_pkg::*;
#(
    parameter int FIXED_DIV = 1,
    parameter int RAT_W     = CHD_DIV_W + 1
) (
    input  logic [CHD_DIV_W-1:0] div,
    output logic [RAT_W-1:0]     ratio
);

    localparam logic [RAT_W-1:0] FIX_V = RAT_W'(FIXED_DIV);

    logic [CHD_DIV_W-1:0] eff_div;

    always_comb eff_div = chd_div_sel(div);

    generate
        if (FIXED_DIV == 1) begin : g_no_post
            always_comb ratio = RAT_W'(eff_div);
        end else begin : g_post
            always_comb ratio = RAT_W'(eff_div) * FIX_V;
        end
    endgenerate

endmodule

// File: rtl/chdiv_counter.sv
module chdiv_counter #(
    parameter int               RAT_W       = 9,
    parameter logic [RAT_W-1:0] RESET_RATIO = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             ptick,
    input  logic [RAT_W-1:0] ratio_next,
    output logic [RAT_W-1:0] cnt_q,
    output logic [RAT_W-1:0] ratio_q,
    output logic             tick_q
);

    logic [RAT_W-1:0] last;

    always_comb last = ratio_q - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            ratio_q <= RESET_RATIO;
            tick_q  <= 1'b0;
        end else if (!run) begin
            cnt_q   <= '0;
            ratio_q <= ratio_next;
            tick_q  <= 1'b0;
        end else if (ptick) begin
            if (cnt_q == last) begin
                cnt_q   <= '0;
                ratio_q <= ratio_next;
                tick_q  <= 1'b1;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
                tick_q  <= 1'b0;
            end
        end else begin
            tick_q <= 1'b0;
        end
    end

endmodule

// File: rtl/chdiv_channel.sv
module chdiv_channel
    import chdiv_pkg::*;
#(
    parameter int        FIXED_DIV  = 1,
    parameter chd_ctrl_t RESET_WORD = '{off: 1'b1, div: 8'd1}
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ptick_i,
    input  logic                  cfg_we_i,
    input  logic [CHD_CTRL_W-1:0] cfg_word_i,
    input  logic                  hold_i,
    output logic                  tick_o
);

    localparam int RAT_W = CHD_DIV_W + $clog2(FIXED_DIV + 1);
    localparam logic [RAT_W-1:0] RESET_RATIO =
        RAT_W'(chd_div_sel(RESET_WORD.div)) * RAT_W'(FIXED_DIV);

    chd_ctrl_t        ctrl_q;
    logic             ch_off;
    logic             run;
    logic [RAT_W-1:0] ratio_next;
    logic [RAT_W-1:0] cnt_q;
    logic [RAT_W-1:0] ratio_q;

    chdiv_ctrl_reg #(
        .RESET_WORD (RESET_WORD)
    ) i_ctrl (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we_i),
        .wdata  (chd_ctrl_t'(cfg_word_i)),
        .ctrl_q (ctrl_q)
    );

    always_comb begin
        ch_off = ctrl_q.off;
        run    = !ch_off && !hold_i;
    end

    chdiv_ratio #(
        .FIXED_DIV (FIXED_DIV),
        .RAT_W     (RAT_W)
    ) i_ratio (
        .div   (ctrl_q.div),
        .ratio (ratio_next)
    );

    chdiv_counter #(
        .RAT_W       (RAT_W),
        .RESET_RATIO (RESET_RATIO)
    ) i_cnt (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .ptick      (ptick_i),
        .ratio_next (ratio_next),
        .cnt_q      (cnt_q),
        .ratio_q    (ratio_q),
        .tick_q     (tick_o)
    );

endmodule

// File: rtl/chdiv_channel_chk.sv
module chdiv_channel_chk #(
    parameter int RAT_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             ptick_i,
    input logic             hold_i,
    input logic             off,
    input logic             run,
    input logic             tick_o,
    input logic [RAT_W-1:0] cnt,
    input logic [RAT_W-1:0] ratio
);

    p_off_silent_r1: assert property (@(posedge clk) disable iff (rst)
        off |=> !tick_o);

    p_hold_silent_r2: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> (!tick_o && cnt == '0));

    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        cnt < ratio);

    p_no_parent_r5: assert property (@(posedge clk) disable iff (rst)
        !ptick_i |=> !tick_o);

    p_reset_state_r6: assert property (@(posedge clk)
        $past(rst) |-> (!tick_o && cnt == '0));

    p_ratio_boundary_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(ratio) |-> (tick_o || !$past(run)));

    p_stop_clears_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0);

endmodule

bind chdiv_channel chdiv_channel_chk #(.RAT_W(RAT_W)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .ptick_i (ptick_i),
    .hold_i  (hold_i),
    .off     (ch_off),
    .run     (run),
    .tick_o  (tick_o),
    .cnt     (cnt_q),
    .ratio   (ratio_q)
);

// File: tb/test_chdiv_channel.sv
`timescale 1ns/1ps
module test_chdiv_channel;

    localparam int FIX = 2;
    localparam int RST_OFF = 1;
    localparam int RST_DIV = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ptick_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [8:0] cfg_word_i = '0;
    logic       hold_i = 1'b0;
    logic       tick_o;

    int    n_checks = 0;
    int    n_fail = 0;
    string phase = "R6";
    bit    done = 0;

    // model state
    int m_off, m_div, m_cnt, m_ratio;
    bit m_tick = 0;

    always #5 clk = ~clk;

    chdiv_channel #(
        .FIXED_DIV  (FIX),
        .RESET_WORD ('{off: 1'b1, div: 8'd3})
    ) i_chdiv_channel (
        .clk        (clk),
        .rst        (rst),
        .ptick_i    (ptick_i),
        .cfg_we_i   (cfg_we_i),
        .cfg_word_i (cfg_word_i),
        .hold_i     (hold_i),
        .tick_o     (tick_o)
    );

    function automatic int eff(input int d);
        return ((d == 0) ? 255 : d) * FIX;
    endfunction

    // Behavioural reference: inputs are stable at the rising edge.
    always @(posedge clk) begin
        if (rst) begin
            m_off = RST_OFF; m_div = RST_DIV; m_cnt = 0;
            m_ratio = eff(RST_DIV); m_tick = 0;
        end else begin
            m_tick = 0;
            if (m_off != 0 || hold_i) begin
                m_cnt = 0;
                m_ratio = eff(m_div);
            end else if (ptick_i) begin
                m_cnt++;
                if (m_cnt == m_ratio) begin
                    m_tick = 1;
                    m_cnt = 0;
                    m_ratio = eff(m_div);
                end
            end
            if (cfg_we_i) begin
                m_off = cfg_word_i[8];
                m_div = cfg_word_i[7:0];
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (tick_o !== m_tick) begin
                n_fail++;
                $display("FAIL %s: tick_o actual %0b expected %0b at %0t",
                         phase, tick_o, m_tick, $time);
            end
        end
    end

    task automatic cycles(input int n, input int period);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ptick_i = (period > 0) && (i % period == 0);
        end
    endtask

    task automatic wr(input bit off, input int div);
        @(negedge clk);
        cfg_we_i = 1'b1;
        cfg_word_i = {off, 8'(div)};
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    initial begin
        // R6: reset state, default word has the channel disabled
        ptick_i = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        cycles(20, 1);
        // R9 / R4: enable, ratio 3*2 = 6, dense parent pulses
        phase = "R9";
        wr(0, 3);
        phase = "R4";
        cycles(40, 1);
        // R4: sparse parent pulses
        cycles(60, 3);
        // R5: silent parent
        phase = "R5";
        cycles(30, 0);
        // R2: hold while disable clear, then R8 restart
        phase = "R2";
        cycles(4, 1);
        @(negedge clk); hold_i = 1'b1;
        cycles(30, 1);
        @(negedge clk); hold_i = 1'b0;
        phase = "R8";
        cycles(30, 1);
        // R1: disable after a partial count, then R8 restart
        phase = "R1";
        cycles(3, 1);
        wr(1, 3);
        cycles(20, 1);
        phase = "R8";
        wr(0, 3);
        cycles(25, 2);
        // R7: divisor change mid-period
        phase = "R7";
        wr(0, 5);
        cycles(13, 1);
        wr(0, 2);
        cycles(40, 1);
        cycles(3, 1);
        wr(0, 7);
        cycles(60, 2);
        // R3: zero divisor -> 255 * FIX
        phase = "R3";
        wr(0, 0);
        cycles(1200, 1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule